// File: doc/BRIEF.md
# Software Command Register Front End

This block is the register-mapped software port of a random-bit generator. A host reaches it over a plain 32-bit register bus with a word address, write and read strobes, and write data. Read data comes back on the cycle after the read strobe. Through this bus, software can do four things:

- set up the generator's control fields;
- lock that setup for the rest of the boot;
- post 32-bit command words to a downstream command port, which uses a valid/ready handshake;
- drain generated 128-bit blocks as 32-bit words.

Downstream logic reports each command's completion with a status flag. The block turns that report into a software-visible acknowledge and a completion interrupt. Software must acknowledge each completion before it may post another command. Generated blocks come from a downstream buffer that shows its head entry, and the block pops that entry once software has read all four words.

Top module: `swcmd_regfront`

Register word addresses:

| Address | Register |
|---------|----------|
| 0 | lock |
| 1 | control |
| 2 | summary |
| 3 | command |
| 4 | command status |
| 5 | output valid |
| 6 | output data |
| 7 | unmapped |

## Requirements
- R1: After reset, the registers are in this state:
  - the lock bit is 1;
  - every control field is 0;
  - no command is pending and `cmd_valid` is 0;
  - ack and error are 0;
  - `irq_done` is 0, and `reg_rdata` is 0.
- R2: Writing the lock register with data bit 0 = 1 clears the lock bit. A write with bit 0 = 0 has no effect. While the lock bit is 0, writes to the control and command registers are ignored, until reset restores the lock bit to 1.
- R3: The control register holds three fields:
  - bit 0 enables the block;
  - bit 1 selects the cipher bypass;
  - bits 19:16 select a buffer depth.

  The three fields drive `ctl_enable`, `ctl_bypass` and `ctl_depth_sel` from the cycle after the write. They read back in the same bit positions, with all other bits 0.
- R4: Software commands are accepted only while the enable bit and `fuse_en` are both 1. Command writes made at any other time are dropped.
- R5: An accepted command write raises `cmd_valid` on the next cycle, with `cmd_word` equal to the written data. Both stay stable until a cycle in which `cmd_ready` is 1.
- R6: The command status register reads as follows:
  - bit 0 is ready: the block is active, no ack is set, and no command is outstanding;
  - bit 1 is ack;
  - bit 4 is the error status, where 0 means success and 1 means error.

  Writing this register with data bit 1 = 1 clears ack.
- R7: A command write made while ack is set, or while a command is outstanding, is dropped.
- R8: A completion report (`done_valid` while a command is outstanding) has three effects on the next cycle:
  - ack is set;
  - bit 4 takes `done_err`;
  - `irq_done` pulses for exactly one cycle.

  If a completion and an ack clear fall in the same cycle, the completion wins.
- R9: Reads of the output data register return the head block's words from least to most significant 32-bit word. `gen_pop` is 1 in the same cycle as the fourth read's strobe, and the word pointer then returns to the first word.
- R10: A read of the output data register while `gen_valid` is 0 returns 0 and does not advance the word pointer.
- R11: In the output valid register, bit 0 is `gen_valid` and bit 1 is `gen_fips` qualified by `gen_valid`.
- R12: In the summary register, bits 3:0 hold the 4-bit depth selected from `depth_in`, where entry i is at bits 4i+3:4i. A selection at or beyond the number of entries reads 0. Bit 31 is `diag_in`, and the other bits are 0.
- R13: `reg_rdata` updates only on a read strobe and holds its value otherwise. The command register and the unmapped address 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after strobe |
| fuse_en | input | 1 | External permission for the software command path |
| cmd_valid | output | 1 | Command word valid |
| cmd_word | output | 32 | Command word |
| cmd_ready | input | 1 | Downstream accepts command |
| done_valid | input | 1 | Command completion report |
| done_err | input | 1 | Completion status, 1 = error |
| irq_done | output | 1 | Command-done interrupt pulse |
| gen_valid | input | 1 | Head generated block present |
| gen_fips | input | 1 | Head block is compliance-certified |
| gen_data | input | 128 | Head generated block |
| gen_pop | output | 1 | Pop head block |
| depth_in | input | 24 | Packed 4-bit buffer depths |
| diag_in | input | 1 | Diagnostic bit |
| ctl_enable | output | 1 | Enable field |
| ctl_bypass | output | 1 | Cipher bypass field |
| ctl_depth_sel | output | 4 | Depth select field |

## Verification
Each result has its own timing:

- read data, control outputs, `cmd_valid` and `cmd_word`, and the `irq_done` pulse all change at the clock edge that samples the strobe or report, so they are due one cycle later;
- `gen_pop` is combinational and is due within the same cycle as the fourth read strobe.

The bench drives all inputs at the falling edge. It checks `gen_pop` 1 ns later, before the edge. It then advances a behavioural model at the rising edge and compares every registered output at the next falling edge, so each comparison lands exactly one edge after its cause.

// File: rtl/swcmd_regfront.sv
module swcmd_regfront #(
  parameter int ADDR_W     = 3,
  parameter int BLK_W      = 128,
  parameter int NUM_DEPTHS = 6,
  parameter int DEPTH_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_we,
  input  logic                          reg_re,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          fuse_en,
  output logic                          cmd_valid,
  output logic [31:0]                   cmd_word,
  input  logic                          cmd_ready,
  input  logic                          done_valid,
  input  logic                          done_err,
  output logic                          irq_done,
  input  logic                          gen_valid,
  input  logic                          gen_fips,
  input  logic [BLK_W-1:0]              gen_data,
  output logic                          gen_pop,
  input  logic [NUM_DEPTHS*DEPTH_W-1:0] depth_in,
  input  logic                          diag_in,
  output logic                          ctl_enable,
  output logic                          ctl_bypass,
  output logic [3:0]                    ctl_depth_sel
);
  localparam int DW    = 32;
  localparam int WORDS = BLK_W / DW;
  localparam int PTR_W = $clog2(WORDS);
  localparam int NSEL  = 16;
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VLD  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(6);

  logic             lock_q, en_q, byp_q, busy_q, ack_q, err_q, irq_q, cv_q;
  logic [3:0]       sel_q;
  logic [DW-1:0]    cw_q, rd_q;
  logic [PTR_W-1:0] ptr_q;
  logic [DW-1:0]    words [WORDS];
  logic [DEPTH_W-1:0] deps [NSEL];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = gen_data[w*DW +: DW];
  end
  for (genvar d = 0; d < NSEL; d++) begin : g_dep
    if (d < NUM_DEPTHS) begin : g_real
      assign deps[d] = depth_in[d*DEPTH_W +: DEPTH_W];
    end else begin : g_none
      assign deps[d] = '0;
    end
  end

  wire sw_active = en_q & fuse_en;
  wire cmd_rdy   = sw_active & ~ack_q & ~busy_q;
  wire wr_lock   = reg_we && reg_addr == A_LOCK;
  wire wr_ctrl   = reg_we && reg_addr == A_CTRL && lock_q;
  wire wr_cmd    = reg_we && reg_addr == A_CMD;
  wire wr_sts    = reg_we && reg_addr == A_STS;
  wire cmd_acc   = wr_cmd & lock_q & cmd_rdy;
  wire done_hit  = done_valid & busy_q;
  wire rd_out    = reg_re && reg_addr == A_OUT && gen_valid;

  assign gen_pop = rd_out && ptr_q == PTR_W'(WORDS-1);

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_LOCK: rd_mux[0] = lock_q;
      A_CTRL: begin
        rd_mux[0]     = en_q;
        rd_mux[1]     = byp_q;
        rd_mux[19:16] = sel_q;
      end
      A_SUM: begin
        rd_mux[DEPTH_W-1:0] = deps[sel_q];
        rd_mux[31]          = diag_in;
      end
      A_STS: begin
        rd_mux[0] = cmd_rdy;
        rd_mux[1] = ack_q;
        rd_mux[4] = err_q;
      end
      A_VLD: begin
        rd_mux[0] = gen_valid;
        rd_mux[1] = gen_valid & gen_fips;
      end
      A_OUT: rd_mux = gen_valid ? words[ptr_q] : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      en_q   <= 1'b0;
      byp_q  <= 1'b0;
      sel_q  <= '0;
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      cv_q   <= 1'b0;
      cw_q   <= '0;
      rd_q   <= '0;
      ptr_q  <= '0;
    end else begin
      if (wr_lock && reg_wdata[0]) lock_q <= 1'b0;
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        byp_q <= reg_wdata[1];
        sel_q <= reg_wdata[19:16];
      end
      if (cmd_acc) begin
        cv_q <= 1'b1;
        cw_q <= reg_wdata;
      end else if (cv_q && cmd_ready) begin
        cv_q <= 1'b0;
      end
      if (cmd_acc)       busy_q <= 1'b1;
      else if (done_hit) busy_q <= 1'b0;
      if (done_hit) begin
        ack_q <= 1'b1;
        err_q <= done_err;
      end else if (wr_sts && reg_wdata[1]) begin
        ack_q <= 1'b0;
      end
      irq_q <= done_hit;
      if (reg_re) rd_q <= rd_mux;
      if (rd_out) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign reg_rdata     = rd_q;
  assign cmd_valid     = cv_q;
  assign cmd_word      = cw_q;
  assign irq_done      = irq_q;
  assign ctl_enable    = en_q;
  assign ctl_bypass    = byp_q;
  assign ctl_depth_sel = sel_q;

  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q);
  p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> $stable({ctl_enable, ctl_bypass, ctl_depth_sel}));
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !cmd_acc) |=> (cmd_valid && $stable(cmd_word)));
  p_no_cmd_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !(wr_sts && reg_wdata[1])) |=> !$rose(cmd_valid));
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  p_pop_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gen_pop |-> (gen_valid && reg_re));
  p_ptr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_valid |=> $stable(ptr_q));
endmodule

// File: tb/sim_swcmd_regfront.sv
`timescale 1ns/1ps
module sim_swcmd_regfront;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]   reg_addr = '0;
  logic         reg_we = 0, reg_re = 0, fuse_en = 0, cmd_ready = 0;
  logic         done_valid = 0, done_err = 0, gen_valid = 0, gen_fips = 0, diag_in = 0;
  logic [31:0]  reg_wdata = '0;
  logic [127:0] gen_data = '0;
  logic [23:0]  depth_in = 24'hA5C3E7;
  logic [31:0]  reg_rdata, cmd_word;
  logic         cmd_valid, irq_done, gen_pop, ctl_enable, ctl_bypass;
  logic [3:0]   ctl_depth_sel;

  swcmd_regfront u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur = "R1";

  logic [2:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;
  bit s_we, s_re, s_cready, s_done, s_derr;
  logic [127:0] q[$];

  bit m_lock, m_en, m_byp, m_busy, m_ack, m_err, m_irq, m_cv;
  logic [3:0]  m_sel;
  logic [31:0] m_cw, m_rd;
  int m_ptr;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lock = 1; m_en = 0; m_byp = 0; m_sel = 0; m_busy = 0; m_ack = 0;
    m_err = 0; m_irq = 0; m_cv = 0; m_cw = 0; m_rd = 0; m_ptr = 0;
  endtask

  function automatic logic [31:0] exp_read(logic [2:0] a, bit gv, logic [127:0] gd);
    logic [31:0] v = 0;
    bit rdy = m_en && fuse_en && !m_ack && !m_busy;
    case (a)
      0: v[0] = m_lock;
      1: begin v[0] = m_en; v[1] = m_byp; v[19:16] = m_sel; end
      2: begin v[3:0] = (m_sel < 6) ? depth_in[m_sel*4 +: 4] : 4'h0; v[31] = diag_in; end
      4: begin v[0] = rdy; v[1] = m_ack; v[4] = m_err; end
      5: begin v[0] = gv; v[1] = gv && gen_fips; end
      6: v = gv ? gd[m_ptr*32 +: 32] : 32'h0;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic compare_regs();
    chk("reg_rdata", reg_rdata, m_rd);
    chk("cmd_valid", {31'b0, cmd_valid}, {31'b0, m_cv});
    if (m_cv) chk("cmd_word", cmd_word, m_cw);
    chk("irq_done", {31'b0, irq_done}, {31'b0, m_irq});
    chk("ctl", {26'b0, ctl_depth_sel, ctl_bypass, ctl_enable}, {26'b0, m_sel, m_byp, m_en});
  endtask

  task automatic step();
    bit gv, exp_pop, rdy;
    logic [127:0] gd;
    gv = q.size() != 0;
    gd = gv ? q[0] : '0;
    reg_addr = s_addr; reg_we = s_we; reg_re = s_re; reg_wdata = s_wdata;
    cmd_ready = s_cready; done_valid = s_done; done_err = s_derr;
    gen_valid = gv; gen_data = gd;
    exp_pop = s_re && s_addr == 6 && gv && m_ptr == 3;
    #1;
    chk("gen_pop", {31'b0, gen_pop}, {31'b0, exp_pop});
    @(posedge clk);
    rdy = m_en && fuse_en && !m_ack && !m_busy;
    if (s_re) m_rd = exp_read(s_addr, gv, gd);
    if (s_re && s_addr == 6 && gv) begin
      if (m_ptr == 3) begin m_ptr = 0; void'(q.pop_front()); end
      else m_ptr++;
    end
    m_irq = s_done && m_busy;
    if (s_done && m_busy) begin m_ack = 1; m_err = s_derr; m_busy = 0; end
    else if (s_we && s_addr == 4 && s_wdata[1]) m_ack = 0;
    if (s_we && s_addr == 3 && m_lock && rdy) begin
      m_cv = 1; m_cw = s_wdata; m_busy = 1;
    end else if (m_cv && s_cready) m_cv = 0;
    if (s_we && s_addr == 1 && m_lock) begin
      m_en = s_wdata[0]; m_byp = s_wdata[1]; m_sel = s_wdata[19:16];
    end
    if (s_we && s_addr == 0 && s_wdata[0]) m_lock = 0;
    @(negedge clk);
    compare_regs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      s_we = 0; s_re = 0; step();
    end
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    s_we = 1; s_re = 0; s_addr = a; s_wdata = d; step(); s_we = 0;
  endtask
  task automatic rd(logic [2:0] a);
    s_re = 1; s_we = 0; s_addr = a; step(); s_re = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    q.delete();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    compare_regs();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    s_we = 0; s_re = 0; s_cready = 0; s_done = 0; s_derr = 0;
    cur = "R1"; do_reset(); idle(2);
    for (int a = 0; a < 8; a++) rd(3'(a));
    cur = "R13"; rd(3); idle(3); rd(7);

    cur = "R3"; wr(1, 32'h0005_0003); rd(1); wr(1, 32'hFFF2_FFFD); rd(1);
    cur = "R12"; wr(1, 32'h0002_0001); diag_in = 1; rd(2);
    wr(1, 32'h0005_0001); rd(2); diag_in = 0;
    wr(1, 32'h0009_0001); rd(2); wr(1, 32'h0000_0001); rd(2);

    cur = "R4"; fuse_en = 0; rd(4); wr(3, 32'h1111_0001); idle(2); rd(4);
    fuse_en = 1; rd(4);

    cur = "R5"; wr(3, 32'hCAFE_0010); idle(3); rd(4);
    s_cready = 1; idle(1); s_cready = 0; idle(1);
    cur = "R7"; wr(3, 32'hDEAD_0000); idle(1);
    cur = "R8"; s_done = 1; s_derr = 0; idle(1); s_done = 0; idle(2);
    cur = "R6"; rd(4);
    cur = "R7"; wr(3, 32'hBAD0_BAD0); idle(2); rd(4);
    cur = "R6"; wr(4, 32'h0000_0001); rd(4); wr(4, 32'h0000_0002); rd(4);
    cur = "R8"; wr(3, 32'h0000_1234); s_cready = 1; idle(1); s_cready = 0;
    s_done = 1; s_derr = 1; idle(1); s_done = 0; rd(4);
    s_done = 1; idle(1); s_done = 0; idle(1);
    s_we = 1; s_addr = 4; s_wdata = 32'h2; step(); s_we = 0; rd(4);
    wr(3, 32'h0000_5678); s_cready = 1;
    s_done = 1; s_derr = 0; s_we = 1; s_addr = 4; s_wdata = 32'h2; step();
    s_we = 0; s_done = 0; s_cready = 0; rd(4);
    wr(4, 32'h2); rd(4);

    cur = "R10"; rd(6); rd(6); rd(5);
    cur = "R11"; q.push_back(128'h4444_4444_3333_3333_2222_2222_1111_1111);
    q.push_back(128'hDDDD_0004_CCCC_0003_BBBB_0002_AAAA_0001);
    gen_fips = 1; rd(5); gen_fips = 0; rd(5); gen_fips = 1;
    cur = "R9"; for (int i = 0; i < 6; i++) rd(6);
    idle(1); rd(6); rd(6);
    cur = "R10"; rd(6); rd(6); rd(5);
    cur = "R9"; q.push_back(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    rd(6); rd(6); rd(6); rd(6); rd(5);

    cur = "R2"; wr(0, 32'h0); rd(0); wr(1, 32'h0001_0001); rd(1);
    wr(0, 32'h1); rd(0); wr(1, 32'h000F_0002); rd(1);
    wr(3, 32'h7777_7777); idle(2); rd(4); wr(0, 32'h1); rd(0);
    do_reset(); rd(0); wr(1, 32'h0003_0001); rd(1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule